// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block holds the tags of a cache with a fixed number of block frames. One parameter sets the associativity, so the same RTL can be built as a direct-mapped, n-way or fully associative cache. Each request carries a block address. The set is picked from the low bits of that address. The tag of every way in the set is compared at the same time, and the block answers hit or miss. On a miss it writes the new tag into a victim way in the same cycle. Data arrays, refill traffic and write-back are handled outside this block.

Victim choice has two steps. A way that holds no valid entry is taken first, the lowest-numbered one if there are several. If every way is valid, the block evicts the way that has gone longest without use. For that it keeps an age rank for every way of every set. On each access the touched way becomes the most recent (age 0). Only the ways that were younger than it move one step older.

The response is registered and appears one cycle after a request is accepted. A later request in the next cycle already sees the tag that the earlier miss installed. A one-cycle invalidate-all input clears every entry.

Top module: `sa_tag_ctrl`

## Requirements
- R1: The set index is the block address modulo SETS = TOTAL_BLOCKS / WAYS, taken from its low log2(SETS) bits. The stored tag is the remaining upper bits, so blocks that share a set but differ in tag never hit on each other.
- R2: A request hits when a valid way of its set holds its tag. The response then has rsp_hit = 1, rsp_way = the matching way and rsp_evict = 0.
- R3: With WAYS = 1, a miss always installs into way 0. rsp_evict is 1 whenever the set already held a valid block.
- R4: On a miss with at least one invalid way in the set, the lowest-numbered invalid way is filled and rsp_evict = 0.
- R5: On a miss with all ways valid, the way whose age is WAYS-1 (the oldest) is replaced, rsp_way names it and rsp_evict = 1.
- R6: On every accepted access the accessed way's age becomes 0. Ways with a smaller age than its old age gain one, and all others keep their age.
- R7: rsp_valid is 1 exactly in the cycle after a request with req_valid and req_ready both 1. A tag installed by a miss is visible to a request accepted in the very next cycle.
- R8: While flush_all is 1, req_ready is 0 and no request is accepted. Afterwards every entry is invalid, so each access misses with rsp_evict = 0 until its block is refilled.
- R9: A synchronous active-high reset clears all entries, sets the age of way w to w in every set, and drives rsp_valid to 0.
- R10: With 4 frames and the block address stream 0, 8, 0, 6, 8, the results are: direct-mapped misses all five; 2-way gives miss, miss, hit, miss, miss; fully associative gives miss, miss, hit, miss, hit. With 8 frames in 2 ways, the same stream evicts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_all | input | 1 | Invalidate every entry this cycle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Block address of the request |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Result was a hit |
| rsp_way | output | WAY_W | Hitting way, or the filled way on a miss |
| rsp_evict | output | 1 | On a miss, the filled way held a valid block |

## Verification
The bench builds four instances with 8-bit addresses and drives them in parallel with the same requests. They are direct-mapped with 4 frames, 2-way with 4 frames, fully associative with 4 frames, and 2-way with 8 frames. This covers the degenerate index (one set) and the degenerate way count (one way) next to the ordinary case. The fixed address stream can therefore be checked against its known hit pattern for every arrangement at once. A behavioural model set up with each build's set and way counts then checks hit, way and eviction on a random stream with enough conflicts to exercise age-ordered replacement.

// File: rtl/sa_tag_ctrl.sv
module sa_tag_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int TOTAL_BLOCKS = 8,
  parameter int WAYS         = 2,
  localparam int WAY_W       = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_all,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_evict
);
  localparam int SETS     = TOTAL_BLOCKS / WAYS;
  localparam int IDX_BITS = (SETS > 1) ? $clog2(SETS) : 0;
  localparam int IDX_W    = (SETS > 1) ? IDX_BITS : 1;
  localparam int TAG_W    = ADDR_W - IDX_BITS;

  logic             vld  [SETS][WAYS];
  logic [TAG_W-1:0] tags [SETS][WAYS];
  logic [WAY_W-1:0] age  [SETS][WAYS];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [WAYS-1:0]  hit_vec;
  logic             hit, inv_found;
  logic [WAY_W-1:0] hit_way, inv_way, old_way, acc_way, acc_age;
  logic             fire;

  assign req_ready = !flush_all;
  assign fire      = req_valid && req_ready;
  assign tag       = req_addr[ADDR_W-1:IDX_BITS];

  if (SETS > 1) begin : g_idx
    assign idx = req_addr[IDX_W-1:0];
  end else begin : g_noidx
    assign idx = '0;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld[idx][w] && (tags[idx][w] == tag);
  end

  always_comb begin
    hit       = |hit_vec;
    hit_way   = '0;
    inv_found = 1'b0;
    inv_way   = '0;
    old_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (!vld[idx][w]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
      if (age[idx][w] == WAY_W'(WAYS - 1)) old_way = WAY_W'(w);
    end
    acc_way = hit ? hit_way : (inv_found ? inv_way : old_way);
    acc_age = age[idx][acc_way];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_evict <= 1'b0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w] <= 1'b0;
          age[s][w] <= WAY_W'(w);
        end
    end else begin
      rsp_valid <= fire;
      if (flush_all) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            vld[s][w] <= 1'b0;
      end
      if (fire) begin
        rsp_hit   <= hit;
        rsp_way   <= acc_way;
        rsp_evict <= !hit && !inv_found;
        if (!hit) begin
          tags[idx][acc_way] <= tag;
          vld[idx][acc_way]  <= 1'b1;
        end
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == acc_way)      age[idx][w] <= '0;
          else if (age[idx][w] < acc_age) age[idx][w] <= age[idx][w] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sa_tag_ctrl_chk.sv
module sa_tag_ctrl_chk #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             flush_all,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [WAY_W-1:0] rsp_way,
  input logic             rsp_evict
);
  // R7
  accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);
  // R7
  no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);
  // R8
  flush_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
    flush_all |-> !req_ready);
  // R8
  flush_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> !rsp_valid);
  // R2
  hit_never_evicts_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> !rsp_evict);
  // R5
  way_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (int'(rsp_way) < WAYS));
  // R9
  reset_clears_rsp_chk: assert property (@(posedge clk)
    rst |=> !rsp_valid);
endmodule

bind sa_tag_ctrl sa_tag_ctrl_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst(rst), .flush_all(flush_all), .req_valid(req_valid),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_way(rsp_way), .rsp_evict(rsp_evict)
);

// File: tb/test_sa_tag_ctrl.sv
`timescale 1ns/1ps
module test_sa_tag_ctrl;
  logic clk = 0, rst = 1, flush_all = 0, req_valid = 0;
  logic [7:0] req_addr = '0;
  logic [3:0] rdy, rv, rh, re;
  logic [0:0] w0, w1, w3;
  logic [1:0] w2;
  logic [1:0] rw [4];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sa_tag_ctrl #(.ADDR_W(8), .TOTAL_BLOCKS(4), .WAYS(1)) i_sa_tag_ctrl_dm (
    .clk(clk), .rst(rst), .flush_all(flush_all), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_addr(req_addr), .rsp_valid(rv[0]), .rsp_hit(rh[0]), .rsp_way(w0), .rsp_evict(re[0]));
  sa_tag_ctrl #(.ADDR_W(8), .TOTAL_BLOCKS(4), .WAYS(2)) i_sa_tag_ctrl_2w (
    .clk(clk), .rst(rst), .flush_all(flush_all), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_addr(req_addr), .rsp_valid(rv[1]), .rsp_hit(rh[1]), .rsp_way(w1), .rsp_evict(re[1]));
  sa_tag_ctrl #(.ADDR_W(8), .TOTAL_BLOCKS(4), .WAYS(4)) i_sa_tag_ctrl_fa (
    .clk(clk), .rst(rst), .flush_all(flush_all), .req_valid(req_valid), .req_ready(rdy[2]),
    .req_addr(req_addr), .rsp_valid(rv[2]), .rsp_hit(rh[2]), .rsp_way(w2), .rsp_evict(re[2]));
  sa_tag_ctrl #(.ADDR_W(8), .TOTAL_BLOCKS(8), .WAYS(2)) i_sa_tag_ctrl_2w8 (
    .clk(clk), .rst(rst), .flush_all(flush_all), .req_valid(req_valid), .req_ready(rdy[3]),
    .req_addr(req_addr), .rsp_valid(rv[3]), .rsp_hit(rh[3]), .rsp_way(w3), .rsp_evict(re[3]));

  assign rw[0] = {1'b0, w0};
  assign rw[1] = {1'b0, w1};
  assign rw[2] = w2;
  assign rw[3] = {1'b0, w3};

  // R10 stream and expected results; bit/field c belongs to instance c (dm, 2w, fa, 2w8)
  localparam int        SEQ   [5] = '{0, 8, 0, 6, 8};
  localparam logic [3:0] T_HIT [5] = '{4'b0000, 4'b0000, 4'b1110, 4'b0000, 4'b1100};
  localparam logic [3:0] T_EV  [5] = '{4'b0000, 4'b0001, 4'b0001, 4'b0010, 4'b0011};
  localparam logic [7:0] T_WAY [5] = '{8'h00, 8'h54, 8'h00, 8'h24, 8'h50};

  int  m_sets [4] = '{4, 2, 1, 4};
  int  m_ways [4] = '{1, 2, 4, 2};
  bit  mv [4][4][4];
  int  mt [4][4][4];
  int  ma [4][4][4];
  bit  eh [4];
  int  ew [4];
  bit  ee [4];

  task automatic model_reset();
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 4; w++) begin
          mv[c][s][w] = 0; mt[c][s][w] = 0; ma[c][s][w] = w;
        end
  endtask

  task automatic model_flush();
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 4; w++) mv[c][s][w] = 0;
  endtask

  task automatic model_access(input int c, input int a);
    int s, t, w, old;
    bit h, inv;
    s = a % m_sets[c]; t = a / m_sets[c];
    h = 0; inv = 0; w = 0;
    for (int j = 0; j < m_ways[c]; j++)
      if (!h && mv[c][s][j] && mt[c][s][j] == t) begin h = 1; w = j; end
    if (!h)
      for (int j = 0; j < m_ways[c]; j++)
        if (!inv && !mv[c][s][j]) begin inv = 1; w = j; end
    if (!h && !inv)
      for (int j = 0; j < m_ways[c]; j++)
        if (ma[c][s][j] == m_ways[c] - 1) w = j;
    eh[c] = h; ew[c] = w; ee[c] = !h && !inv;
    old = ma[c][s][w];
    for (int j = 0; j < m_ways[c]; j++)
      if (j == w) ma[c][s][j] = 0;
      else if (ma[c][s][j] < old) ma[c][s][j]++;
    if (!h) begin mv[c][s][w] = 1; mt[c][s][w] = t; end
  endtask

  task automatic check(input bit ok, input string tag, input int c,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s inst %0d: actual %0h expected %0h", tag, c, act, exp);
    end
  endtask

  // one request per cycle; sampled at the following negedge after the response register
  task automatic access(input int a, input string tag);
    req_valid = 1; req_addr = 8'(a);
    for (int c = 0; c < 4; c++) model_access(c, a);
    @(negedge clk);
    for (int c = 0; c < 4; c++)
      check(rv[c] && rh[c] == eh[c] && int'(rw[c]) == ew[c] && re[c] == ee[c], tag, c,
            {rv[c], rh[c], rw[c], re[c]}, {1'b1, eh[c], 2'(ew[c]), ee[c]});
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    for (int c = 0; c < 4; c++) check(rv[c] == 0 && rdy[c] == 1, "R9", c, {rv[c], rdy[c]}, 2'b01);

    // R10 table walk, also compared with the model
    for (int i = 0; i < 5; i++) begin
      access(SEQ[i], "R2");
      for (int c = 0; c < 4; c++)
        check(rh[c] == T_HIT[i][c] && re[c] == T_EV[i][c] && rw[c] == T_WAY[i][2*c +: 2],
              "R10", c, {rh[c], re[c], rw[c]}, {T_HIT[i][c], T_EV[i][c], T_WAY[i][2*c +: 2]});
    end
    req_valid = 0;
    @(negedge clk);

    // R1 same set, different tag; R3 direct-mapped overwrite
    access(1, "R1"); access(5, "R3"); access(1, "R3"); access(5, "R1");
    // R7 back-to-back fill then hit
    access(9, "R7"); access(9, "R7");
    // R4 R5 R6 age ordering on a set that fills
    access(2, "R4"); access(10, "R4"); access(18, "R5"); access(26, "R5");
    access(2, "R6"); access(34, "R6"); access(10, "R6");
    req_valid = 0;
    @(negedge clk);
    for (int c = 0; c < 4; c++) check(rv[c] == 0, "R7", c, rv[c], 0);

    // R8 flush with a request present
    flush_all = 1; req_valid = 1; req_addr = 8'd9;
    #1;
    for (int c = 0; c < 4; c++) check(rdy[c] == 0, "R8", c, rdy[c], 0);
    @(negedge clk);
    flush_all = 0; req_valid = 0;
    model_flush();
    for (int c = 0; c < 4; c++) check(rv[c] == 0, "R8", c, rv[c], 0);
    access(9, "R8"); access(2, "R8"); access(9, "R8");

    // random stream against the model
    for (int i = 0; i < 400; i++) access(int'($urandom % 16), "R6");
    req_valid = 0;

    // R9 reset mid-run
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
    for (int c = 0; c < 4; c++) check(rv[c] == 0, "R9", c, rv[c], 0);
    access(0, "R9"); access(4, "R9"); access(0, "R9");
    req_valid = 0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule